// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit style processor core and chooses which of five interrupt sources is served next. The top source cannot be masked. The next three are maskable and each has its own fixed restart vector. The lowest source is a general request: instead of a vector, it gets an active-low acknowledge so that the core can fetch a supplied instruction. Every request is latched as pending until it is granted. The block acts only when the core reports an instruction boundary, so the current instruction always completes first.

On a grant the block raises a one-cycle take strobe. The strobe tells the core to push the supplied return address and then branch. Alongside it the block presents the vector and the return address that was captured at the boundary. A global enable gates all maskable sources. Any grant clears that enable, and only an explicit set pulse from the core raises it again. A 3-bit mask register blocks the three restart sources one by one, and a blocked source keeps its pending latch.

Top module: `irq_vector_ctl`

## Requirements
- R1: While `rst` is high, and afterwards until the first grant, `take_o`=0, `ack_n_o`=1, `vector_o`=0 and `ret_addr_o`=0. Reset clears the global enable and all mask bits.
- R2: `req_i` bit 4 has the highest priority and bit 0 the lowest. Among the eligible pending sources, the highest bit is granted. The vectors are: bit 4 -> 0x0024, bit 3 -> 0x003C, bit 2 -> 0x0034, bit 1 -> 0x002C.
- R3: Source bit 4 is granted regardless of the global enable and of every mask bit.
- R4: A write with `mask_we_i`=1 loads `mask_wdata_i`: bit 2 blocks source 3, bit 1 blocks source 2 and bit 0 blocks source 1. A blocked source keeps its pending latch and is granted once its mask bit is cleared.
- R5: When source 0 is granted, `take_o`=1, `ack_n_o`=0 and `vector_o`=0 for that cycle. It needs the global enable.
- R6: A grant happens only at a clock edge where `boundary_i`=1. The outputs show the grant in the cycle after that edge. A request must have been sampled at an earlier edge than the boundary edge.
- R7: A grant is a single-cycle `take_o` pulse. `ret_addr_o` carries the `next_pc_i` value sampled at the boundary edge.
- R8: A granted source's pending bit clears at the grant edge, so a single request pulse is granted exactly once.
- R9: Any grant clears the global enable. `ien_set_i` sets it again. If a grant and `ien_set_i` fall on the same edge, the grant wins and the enable stays clear.
- R10: At a boundary with no eligible source, `take_o` stays 0, `vector_o` stays 0 and `ack_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Interrupt requests, bit 4 highest priority |
| boundary_i | input | 1 | Core is at an instruction boundary |
| next_pc_i | input | 16 | Address of the next instruction |
| ien_set_i | input | 1 | Set the global interrupt enable |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | Mask bits for sources 3, 2 and 1 |
| take_o | output | 1 | Grant: push return address and branch |
| ack_n_o | output | 1 | Active-low acknowledge for source 0 |
| vector_o | output | 16 | Branch vector, 0 when idle or for source 0 |
| ret_addr_o | output | 16 | Return address to push |

## Verification
Each result arrives a fixed number of cycles after its stimulus. A request takes effect at the edge after it is sampled. A mask write or enable set becomes visible to arbitration one edge after it is presented. A grant decided at a boundary edge shows on the outputs for exactly the cycle that follows. The bench therefore drives every input just after a falling edge, so each change is captured by exactly one rising edge. It samples the outputs at the falling edge that follows the boundary edge. In the idle cycles before and after that edge, it confirms that `take_o` is low.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NSRC = 5;
    localparam int NMSK = NSRC - 2;
    localparam int AW   = 16;

    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_LOW  = 3'd1,
        SRC_MID  = 3'd2,
        SRC_HIGH = 3'd3,
        SRC_NMI  = 3'd4
    } src_e;

    typedef struct packed {
        logic hit;
        src_e id;
    } pick_t;

    typedef struct packed {
        logic          take;
        logic          ack_n;
        logic [AW-1:0] vec;
        logic [AW-1:0] ret;
    } grant_t;

    function automatic logic [AW-1:0] vec_of(src_e s);
        case (s)
            SRC_NMI:  return AW'(16'h0024);
            SRC_HIGH: return AW'(16'h003C);
            SRC_MID:  return AW'(16'h0034);
            SRC_LOW:  return AW'(16'h002C);
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[i] <= 1'b0;
            else
                pend_o[i] <= (pend_o[i] | req_i[i]) & ~clr_i[i];
        end
    end
endmodule

// File: rtl/irq_gate_state.sv
module irq_gate_state #(
    parameter int M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we_i,
    input  logic [M-1:0] mask_wdata_i,
    input  logic         ien_set_i,
    input  logic         grant_i,
    output logic         ien_o,
    output logic [M-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst)
            ien_o <= 1'b0;
        else if (grant_i)
            ien_o <= 1'b0;
        else if (ien_set_i)
            ien_o <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= '0;
        else if (mask_we_i)
            mask_o <= mask_wdata_i;
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] elig_i,
    output logic [N-1:0] win_o,
    output pick_t        pick_o
);
    for (genvar i = 0; i < N; i++) begin : g_win
        if (i == N - 1) begin : g_top
            assign win_o[i] = elig_i[i];
        end else begin : g_rest
            assign win_o[i] = elig_i[i] & ~(|elig_i[N-1:i+1]);
        end
    end

    always_comb begin
        pick_o.hit = |win_o;
        pick_o.id  = SRC_EXT;
        for (int i = 0; i < N; i++) begin
            if (win_o[i]) pick_o.id = src_e'(3'(i));
        end
    end
endmodule

// File: rtl/irq_grant_reg.sv
module irq_grant_reg
    import irq_vec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fire_i,
    input  pick_t         pick_i,
    input  logic [AW-1:0] next_pc_i,
    output grant_t        q_o
);
    localparam grant_t IDLE = '{take: 1'b0, ack_n: 1'b1, vec: '0, ret: '0};

    always_ff @(posedge clk) begin
        if (rst || !fire_i) begin
            q_o <= IDLE;
        end else begin
            q_o.take  <= 1'b1;
            q_o.ack_n <= (pick_i.id != SRC_EXT);
            q_o.vec   <= vec_of(pick_i.id);
            q_o.ret   <= next_pc_i;
        end
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_vec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      req_i,
    input  logic                 boundary_i,
    input  logic [AW-1:0]        next_pc_i,
    input  logic                 ien_set_i,
    input  logic                 mask_we_i,
    input  logic [NMSK-1:0]      mask_wdata_i,
    output logic                 take_o,
    output logic                 ack_n_o,
    output logic [AW-1:0]        vector_o,
    output logic [AW-1:0]        ret_addr_o
);
    logic [NSRC-1:0] pend, elig, win, clr;
    logic [NMSK-1:0] mask;
    logic            ien;
    logic            fire;
    pick_t           pick;
    grant_t          gq;

    irq_pend_bank #(.N(NSRC)) u_pend (
        .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr), .pend_o(pend)
    );

    irq_gate_state #(.M(NMSK)) u_gate (
        .clk(clk), .rst(rst), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .ien_set_i(ien_set_i), .grant_i(fire), .ien_o(ien), .mask_o(mask)
    );

    // top source ignores enable and mask; restart sources honour both
    always_comb begin
        elig[NSRC-1]   = pend[NSRC-1];
        elig[NSRC-2:1] = pend[NSRC-2:1] & ~mask & {NMSK{ien}};
        elig[0]        = pend[0] & ien;
    end

    irq_prio_pick #(.N(NSRC)) u_pick (
        .elig_i(elig), .win_o(win), .pick_o(pick)
    );

    assign fire = boundary_i & pick.hit;
    assign clr  = fire ? win : '0;

    irq_grant_reg u_out (
        .clk(clk), .rst(rst), .fire_i(fire), .pick_i(pick),
        .next_pc_i(next_pc_i), .q_o(gq)
    );

    assign take_o     = gq.take;
    assign ack_n_o    = gq.ack_n;
    assign vector_o   = gq.vec;
    assign ret_addr_o = gq.ret;
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk (
    input logic        clk,
    input logic        rst,
    input logic        boundary_i,
    input logic [15:0] next_pc_i,
    input logic        take_o,
    input logic        ack_n_o,
    input logic [15:0] vector_o,
    input logic [15:0] ret_addr_o
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!take_o && ack_n_o && vector_o == 16'h0 && ret_addr_o == 16'h0));

    a_r6_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(boundary_i));

    a_r7_ret_capture: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ret_addr_o == $past(next_pc_i));

    a_r5_ack_shape: assert property (@(posedge clk) disable iff (rst)
        !ack_n_o |-> (take_o && vector_o == 16'h0));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vector_o == 16'h0 && ack_n_o));

    a_r2_vec_legal: assert property (@(posedge clk) disable iff (rst)
        (take_o && ack_n_o) |-> (vector_o == 16'h0024 || vector_o == 16'h003C ||
                                 vector_o == 16'h0034 || vector_o == 16'h002C));

    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (take_o && $past(take_o)) |-> (vector_o == 16'h0024 && ack_n_o));
endmodule

bind irq_vector_ctl irq_vector_chk u_chk (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .next_pc_i(next_pc_i),
    .take_o(take_o), .ack_n_o(ack_n_o), .vector_o(vector_o), .ret_addr_o(ret_addr_o)
);

// File: tb/sim_irq_vector_ctl.sv
module sim_irq_vector_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  req_i = '0;
    logic        boundary_i = 1'b0;
    logic [15:0] next_pc_i = '0;
    logic        ien_set_i = 1'b0;
    logic        mask_we_i = 1'b0;
    logic [2:0]  mask_wdata_i = '0;
    logic        take_o, ack_n_o;
    logic [15:0] vector_o, ret_addr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_vector_ctl u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .boundary_i(boundary_i),
        .next_pc_i(next_pc_i), .ien_set_i(ien_set_i), .mask_we_i(mask_we_i),
        .mask_wdata_i(mask_wdata_i), .take_o(take_o), .ack_n_o(ack_n_o),
        .vector_o(vector_o), .ret_addr_o(ret_addr_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare the whole grant output group
    task automatic expect_out(input string tag, input logic tk, input logic an,
                              input logic [15:0] vec, input logic [15:0] ret);
        chk({tag, " take"}, 16'(take_o), 16'(tk));
        chk({tag, " ack_n"}, 16'(ack_n_o), 16'(an));
        chk({tag, " vector"}, vector_o, vec);
        chk({tag, " ret"}, ret_addr_o, ret);
    endtask

    task automatic pulse_req(input logic [4:0] m);
        req_i = m; tick(); req_i = '0;
    endtask

    task automatic set_ien();
        ien_set_i = 1'b1; tick(); ien_set_i = 1'b0;
    endtask

    task automatic wr_mask(input logic [2:0] m);
        mask_we_i = 1'b1; mask_wdata_i = m; tick(); mask_we_i = 1'b0;
    endtask

    // one boundary edge; outputs sampled at the following falling edge
    task automatic bnd(input logic [15:0] pc, input logic en);
        next_pc_i = pc; boundary_i = 1'b1; ien_set_i = en;
        tick();
        boundary_i = 1'b0; ien_set_i = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1 after reset", 1'b0, 1'b1, 16'h0, 16'h0);
        bnd(16'h1111, 1'b0);
        expect_out("R10 no source", 1'b0, 1'b1, 16'h0, 16'h0);
    endtask

    task automatic t_nonmask();
        wr_mask(3'b111);
        pulse_req(5'b10000);
        bnd(16'h2000, 1'b0);
        expect_out("R3 top source unmaskable", 1'b1, 1'b1, 16'h0024, 16'h2000);
        pulse_req(5'b00001);
        bnd(16'h2002, 1'b0);
        expect_out("R9 general blocked without enable", 1'b0, 1'b1, 16'h0, 16'h0);
        wr_mask(3'b000);
        set_ien();
        bnd(16'h2004, 1'b0);
        expect_out("R5 general acknowledge", 1'b1, 1'b0, 16'h0, 16'h2004);
    endtask

    task automatic t_priority();
        set_ien();
        pulse_req(5'b11111);
        bnd(16'h3000, 1'b0);
        expect_out("R2 top first", 1'b1, 1'b1, 16'h0024, 16'h3000);
        bnd(16'h3001, 1'b0);
        expect_out("R9 enable cleared by grant", 1'b0, 1'b1, 16'h0, 16'h0);
        set_ien(); bnd(16'h3002, 1'b0);
        expect_out("R2 source 3", 1'b1, 1'b1, 16'h003C, 16'h3002);
        set_ien(); bnd(16'h3003, 1'b0);
        expect_out("R2 source 2", 1'b1, 1'b1, 16'h0034, 16'h3003);
        set_ien(); bnd(16'h3004, 1'b0);
        expect_out("R2 source 1", 1'b1, 1'b1, 16'h002C, 16'h3004);
        set_ien(); bnd(16'h3005, 1'b0);
        expect_out("R5 source 0 last", 1'b1, 1'b0, 16'h0, 16'h3005);
        set_ien(); bnd(16'h3006, 1'b0);
        expect_out("R8 all pending cleared", 1'b0, 1'b1, 16'h0, 16'h0);
    endtask

    task automatic t_mask();
        wr_mask(3'b100);
        pulse_req(5'b01000);
        bnd(16'h4000, 1'b0);
        expect_out("R4 masked source 3", 1'b0, 1'b1, 16'h0, 16'h0);
        wr_mask(3'b000);
        bnd(16'h4001, 1'b0);
        expect_out("R4 pending kept through mask", 1'b1, 1'b1, 16'h003C, 16'h4001);
        set_ien();
        wr_mask(3'b010);
        pulse_req(5'b00110);
        bnd(16'h4002, 1'b0);
        expect_out("R4 source 2 masked, source 1 wins", 1'b1, 1'b1, 16'h002C, 16'h4002);
        set_ien();
        bnd(16'h4003, 1'b0);
        expect_out("R4 source 2 still masked", 1'b0, 1'b1, 16'h0, 16'h0);
        wr_mask(3'b000);
        bnd(16'h4004, 1'b0);
        expect_out("R4 source 2 after unmask", 1'b1, 1'b1, 16'h0034, 16'h4004);
    endtask

    task automatic t_boundary();
        set_ien();
        pulse_req(5'b00010);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R6 no grant without boundary", 16'(take_o), 16'h0);
        end
        bnd(16'hBEEF, 1'b0);
        expect_out("R7 grant with return address", 1'b1, 1'b1, 16'h002C, 16'hBEEF);
        tick();
        chk("R7 single-cycle take", 16'(take_o), 16'h0);
        set_ien();
        req_i = 5'b00100;
        bnd(16'h5000, 1'b0);
        req_i = '0;
        expect_out("R6 request not yet sampled", 1'b0, 1'b1, 16'h0, 16'h0);
        bnd(16'h5001, 1'b0);
        expect_out("R6 grant at next boundary", 1'b1, 1'b1, 16'h0034, 16'h5001);
    endtask

    task automatic t_race();
        set_ien();
        pulse_req(5'b00110);
        bnd(16'h6000, 1'b1);
        expect_out("R9 grant alongside enable set", 1'b1, 1'b1, 16'h0034, 16'h6000);
        bnd(16'h6001, 1'b0);
        expect_out("R9 grant wins over set", 1'b0, 1'b1, 16'h0, 16'h0);
        set_ien();
        bnd(16'h6002, 1'b0);
        expect_out("R8 remaining source granted once", 1'b1, 1'b1, 16'h002C, 16'h6002);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_nonmask();
        t_priority();
        t_mask();
        t_boundary();
        t_race();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule